// File: doc/BRIEF.md
# Tuning and Temperature Register Slave on a Two-Wire Bus

This block is a slave on an I2C bus that serves four byte-wide registers. Two of them form a 16-bit frequency-tuning word that the block drives out in parallel to the oscillator control logic. The other two show a 12-bit temperature reading supplied by an on-chip conversion engine. The bus lines arrive as plain inputs and pass through synchronisers clocked by a system clock at least sixteen times the SCL rate. The block pulls SDA low through a single output enable, which goes to an open-drain pad.

The conversion engine presents each new reading with a one-cycle valid strobe, and every strobe overwrites an internal temperature register. The bus never reads that register directly. It reads a user copy, and the user copy is refreshed from the internal register at two points only: when a write-direction address byte is acknowledged, and when a word address byte arrives. A read burst that starts at the temperature MSB therefore returns both halves of one sample, even if a conversion finishes in the middle of the burst. The word pointer advances after every data byte and wraps from 03h to 00h. After reset the block raises a one-cycle request for a first conversion.

Top module: `tune_temp_i2c_slave`

## Requirements
- R1: The block acknowledges (drives SDA low on the 9th clock) an address byte whose upper seven bits equal DEV_ADDR. For any other address it leaves SDA released and stays off the bus until the next START. It never drives SDA while idle.
- R2: In a write, the first data byte after the address byte is the word pointer. It selects register 00h (tuning high, tune_word[15:8]) or 01h (tuning low, tune_word[7:0]). A data byte written to 00h or 01h appears on tune_word once its acknowledge clock has ended.
- R3: A data byte written to 02h or 03h is acknowledged and leaves tune_word and the temperature contents unchanged.
- R4: A read of 02h returns temperature bits 11:4. A read of 03h returns temperature bits 3:0 in bits 7:4, with bits 3:0 reading zero.
- R5: After reset, tune_word is 0000h, the temperature reads as code 190h (bytes 19h, 00h), and conv_start is high for exactly one clock cycle.
- R6: Each temp_vld strobe loads temp_code into the internal register. The readable copy is refreshed from that register only when a write address is acknowledged and when a word pointer byte is received. A conversion that completes after that point is therefore not visible in the same read burst.
- R7: The word pointer increments after each data byte, read or written, and wraps from 03h to 00h.
- R8: A repeated START begins a new address phase and keeps the word pointer. A read burst ends when the master returns NACK, and the block then releases SDA.
- R9: A START or STOP that arrives before a byte is complete abandons that byte without committing it. A STOP releases SDA on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen at the pad |
| sda_in | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| temp_code | input | TEMP_W | Temperature reading from the conversion engine |
| temp_vld | input | 1 | One-cycle strobe marking temp_code valid |
| conv_start | output | 1 | One-cycle request for the first conversion after reset |
| tune_word | output | 16 | Frequency tuning word {reg 00h, reg 01h} |

## Verification
The bench sends a new conversion result after the word pointer has been set to 02h and before the repeated START of the read. A design that refreshed the copy at the wrong point, or read the internal register directly, would return the new MSB together with the old LSB, or the new value too early. Bursts starting at 02h and 03h cross the wrap from 03h to 00h. A design that saturated the pointer, or let it run past 03h, would return the wrong tuning bytes. Bytes cut short by a STOP and by a repeated START are checked as well: a design that committed a partial byte, or moved the pointer without a full byte, would change tune_word or read back from the wrong register. Writes to the temperature addresses confirm that they are acknowledged and leave the tuning word alone.

// File: rtl/tune_temp_pkg.sv
package tune_temp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WPTR, ST_WPTR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK
  } slv_st_e;

  localparam logic [1:0] RA_TUNE_HI = 2'd0;
  localparam logic [1:0] RA_TUNE_LO = 2'd1;
  localparam logic [1:0] RA_TEMP_HI = 2'd2;
  localparam logic [1:0] RA_TEMP_LO = 2'd3;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_ff, sda_ff;
  logic          scl_d, sda_d;
  logic          scl_s;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[LAST-1:0], scl_in};
          sda_ff <= {sda_ff[LAST-1:0], sda_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_in;
          sda_ff <= sda_in;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_ff[LAST];
      sda_d <= sda_ff[LAST];
    end
  end

  assign scl_s     = scl_ff[LAST];
  assign sda_s     = sda_ff[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tune_temp_regs.sv
module tune_temp_regs
  import tune_temp_pkg::*;
#(
  parameter int               TEMP_W   = 12,
  parameter logic [TEMP_W-1:0] TEMP_RST = 12'h190
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              temp_vld,
  input  logic              snap,
  output logic [15:0]       tune_word,
  output logic [TEMP_W-1:0] temp_usr,
  output logic              conv_start
);
  logic [7:0]        hi_q, hi_n, lo_q, lo_n;
  logic [TEMP_W-1:0] tint_q, tint_n, tusr_q, tusr_n;
  logic              boot_q, conv_q;

  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    if (wr_en) begin
      case (wr_addr)
        RA_TUNE_HI: hi_n = wr_data;
        RA_TUNE_LO: lo_n = wr_data;
        default:    ;
      endcase
    end
    tint_n = temp_vld ? temp_code : tint_q;
    tusr_n = snap ? tint_q : tusr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      tint_q <= TEMP_RST;
      tusr_q <= TEMP_RST;
      boot_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      tint_q <= tint_n;
      tusr_q <= tusr_n;
      boot_q <= 1'b1;
      conv_q <= ~boot_q;
    end
  end

  assign tune_word  = {hi_q, lo_q};
  assign temp_usr   = tusr_q;
  assign conv_start = conv_q;
endmodule

// File: rtl/tune_temp_i2c_slave.sv
module tune_temp_i2c_slave
  import tune_temp_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h52,
  parameter int                TEMP_W      = 12,
  parameter logic [TEMP_W-1:0] TEMP_RST    = 12'h190,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              temp_vld,
  output logic              conv_start,
  output logic [15:0]       tune_word
);
  localparam int PAD_W = 16 - TEMP_W;

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  slv_st_e           st_q, st_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [7:0]        sh_q, sh_n;
  logic [1:0]        ptr_q, ptr_n;
  logic              rw_q, rw_n, oe_q, oe_n;
  logic              wr_en, snap;
  logic [7:0]        rd_byte;
  logic [TEMP_W-1:0] temp_usr;

  tune_temp_regs #(.TEMP_W(TEMP_W), .TEMP_RST(TEMP_RST)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(ptr_q),
    .wr_data(sh_q), .temp_code(temp_code), .temp_vld(temp_vld),
    .snap(snap), .tune_word(tune_word), .temp_usr(temp_usr),
    .conv_start(conv_start)
  );

  always_comb begin
    case (ptr_q)
      RA_TUNE_HI: rd_byte = tune_word[15:8];
      RA_TUNE_LO: rd_byte = tune_word[7:0];
      RA_TEMP_HI: rd_byte = temp_usr[TEMP_W-1 -: 8];
      default:    rd_byte = {temp_usr[TEMP_W-9:0], {PAD_W{1'b0}}};
    endcase
  end

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    ptr_n = ptr_q;
    rw_n  = rw_q;
    oe_n  = oe_q;
    wr_en = 1'b0;
    snap  = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WPTR, ST_WDAT: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_n = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                st_n = ST_ADDR_ACK;
                oe_n = 1'b1;
                rw_n = sh_q[0];
                snap = ~sh_q[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st_q == ST_WPTR) begin
              st_n  = ST_WPTR_ACK;
              oe_n  = 1'b1;
              ptr_n = sh_q[1:0];
              snap  = 1'b1;
            end else begin
              st_n = ST_WDAT_ACK;
              oe_n = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              st_n  = ST_RDAT;
              sh_n  = rd_byte;
              oe_n  = ~rd_byte[7];
              cnt_n = 4'd1;
            end else begin
              st_n = ST_WPTR;
              oe_n = 1'b0;
            end
          end
        end
        ST_WPTR_ACK: begin
          if (scl_fall) begin
            st_n = ST_WDAT;
            oe_n = 1'b0;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            st_n  = ST_WDAT;
            oe_n  = 1'b0;
            wr_en = 1'b1;
            ptr_n = ptr_q + 2'd1;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              st_n  = ST_RDAT_ACK;
              oe_n  = 1'b0;
              cnt_n = '0;
              ptr_n = ptr_q + 2'd1;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              oe_n  = ~sh_q[6];
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        ST_RDAT_ACK: begin
          if (scl_rise && sda_s) begin
            st_n = ST_IDLE;
          end else if (scl_fall) begin
            st_n  = ST_RDAT;
            sh_n  = rd_byte;
            oe_n  = ~rd_byte[7];
            cnt_n = 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      rw_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      ptr_q <= ptr_n;
      rw_q  <= rw_n;
      oe_q  <= oe_n;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/tune_temp_i2c_slave_chk.sv
module tune_temp_i2c_slave_chk
  import tune_temp_pkg::*;
#(
  parameter int TEMP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input slv_st_e           st_q,
  input logic              sda_oe,
  input logic              stop_det,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic              snap,
  input logic [15:0]       tune_word,
  input logic [TEMP_W-1:0] temp_usr,
  input logic              conv_start
);
  // R1: an idle slave never pulls the data line
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe);

  // R2: the tuning word moves only on a committed write
  p_tune_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tune_word));

  // R3: commits aimed at the temperature bytes leave the tuning word alone
  p_temp_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[1]) |=> $stable(tune_word));

  // R5: the conversion request lasts a single cycle
  p_conv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R6: the readable temperature changes only at a snapshot point
  p_usr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(temp_usr));

  // R9: STOP frees the line on the next cycle
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind tune_temp_i2c_slave tune_temp_i2c_slave_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .st_q(st_q), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_en(wr_en), .wr_addr(ptr_q), .snap(snap),
  .tune_word(tune_word), .temp_usr(temp_usr), .conv_start(conv_start)
);

// File: tb/tune_temp_i2c_slave_tb.sv
`timescale 1ns/1ps
module tune_temp_i2c_slave_tb;
  localparam logic [6:0] DEV = 7'h52;
  localparam int QTR = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [11:0] temp_code = '0;
  logic        temp_vld = 1'b0;
  logic        sda_oe, conv_start;
  logic [15:0] tune_word;
  wire         sda_bus = m_sda & ~sda_oe;

  int n_tests = 0;
  int n_fail = 0;
  int conv_seen = 0;
  bit done = 0;
  logic [7:0] rd_buf [4];
  bit ack_bit;

  always #2.5 clk = ~clk;

  tune_temp_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .temp_code(temp_code), .temp_vld(temp_vld),
    .conv_start(conv_start), .tune_word(tune_word)
  );

  always @(negedge clk) if (conv_start) conv_seen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); ack = sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_bus; qw(); scl = 1'b0;
    end
    qw();
    m_sda = nack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); m_sda = 1'b1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    bit k;
    bus_start(); send_byte({DEV, 1'b0}, k); send_byte({6'd0, a}, k);
    send_byte(d, k); bus_stop();
  endtask

  task automatic reg_read(input logic [1:0] a, input int n);
    bit k;
    bus_start(); send_byte({DEV, 1'b0}, k); send_byte({6'd0, a}, k);
    bus_start(); send_byte({DEV, 1'b1}, k);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rd_buf[i]);
    bus_stop();
  endtask

  // {addr, data written, byte read back, tune_word after}
  localparam logic [33:0] VEC [6] = '{
    {2'd0, 8'hA5, 8'hA5, 16'hA500},
    {2'd1, 8'h3C, 8'h3C, 16'hA53C},
    {2'd2, 8'hFF, 8'h19, 16'hA53C},
    {2'd3, 8'hFF, 8'h00, 16'hA53C},
    {2'd0, 8'h5A, 8'h5A, 16'h5A3C},
    {2'd1, 8'hC3, 8'hC3, 16'h5AC3}
  };

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit k;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R5: reset state
    check("R5 tune reset", tune_word, 16'h0000);
    check("R5 line released", sda_oe, 1'b0);
    check("R5 conv pulse count", conv_seen, 1);
    reg_read(2'd2, 2);
    check("R5 R4 temp msb", rd_buf[0], 8'h19);
    check("R5 R4 temp lsb", rd_buf[1], 8'h00);

    // R1: address match and mismatch
    bus_start(); send_byte({DEV, 1'b0}, k);
    check("R1 ack on match", k, 1'b0);
    bus_stop();
    bus_start(); send_byte({7'h30, 1'b0}, k);
    check("R1 nack on mismatch", k, 1'b1);
    check("R1 no drive after mismatch", sda_oe, 1'b0);
    bus_stop();

    // R2 R3 R4: table of write-then-read vectors
    foreach (VEC[i]) begin
      reg_write(VEC[i][33:32], VEC[i][31:24]);
      check(VEC[i][33] ? "R3 tune after temp write" : "R2 tune after write",
            tune_word, VEC[i][15:0]);
      reg_read(VEC[i][33:32], 1);
      check(VEC[i][33] ? "R3 R4 temp readback" : "R2 readback",
            rd_buf[0], VEC[i][23:16]);
    end

    // R6: conversion lands after the pointer byte, before the read phase
    bus_start(); send_byte({DEV, 1'b0}, k); send_byte(8'h02, k);
    temp_code = 12'h7F3; temp_vld = 1'b1; @(negedge clk); temp_vld = 1'b0;
    bus_start(); send_byte({DEV, 1'b1}, k);
    recv_byte(1'b0, rd_buf[0]); recv_byte(1'b1, rd_buf[1]);
    check("R8 released after nack", sda_oe, 1'b0);
    bus_stop();
    check("R6 coherent old msb", rd_buf[0], 8'h19);
    check("R6 coherent old lsb", rd_buf[1], 8'h00);

    // R7: burst across the wrap, which also refreshes the copy (R6)
    reg_read(2'd2, 4);
    check("R6 R4 new msb", rd_buf[0], 8'h7F);
    check("R6 R4 new lsb", rd_buf[1], 8'h30);
    check("R7 wrap to 00", rd_buf[2], 8'h5A);
    check("R7 wrap to 01", rd_buf[3], 8'hC3);

    // R7: write burst wraps from 03 to 00 and 01
    bus_start(); send_byte({DEV, 1'b0}, k); send_byte(8'h03, k);
    send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k);
    bus_stop();
    check("R7 write wrap", tune_word, 16'h2233);

    // R9: STOP in the middle of a data byte
    bus_start(); send_byte({DEV, 1'b0}, k); send_byte(8'h00, k);
    send_bits(8'h00, 4); qw();
    bus_stop();
    check("R9 stop mid byte no commit", tune_word, 16'h2233);
    check("R9 line released", sda_oe, 1'b0);

    // R8 R9: repeated START mid byte, then read from the kept pointer
    bus_start(); send_byte({DEV, 1'b0}, k); send_byte(8'h01, k);
    send_bits(8'h00, 4); qw();
    bus_start(); send_byte({DEV, 1'b1}, k);
    recv_byte(1'b1, rd_buf[0]);
    bus_stop();
    check("R9 restart mid byte no commit", tune_word, 16'h2233);
    check("R8 pointer kept across restart", rd_buf[0], 8'h33);
    check("R5 single conv pulse overall", conv_seen, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule